// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a small processor core with a 16-bit accumulator. Instructions and data sit in one external memory of 16-bit words. The core reaches that memory through a single synchronous port, which has one address bus, a write-data bus, a read-data bus and separate read and write strobes. A Moore-style control state machine steps through each instruction in order: initialise after reset, fetch, wait for memory, decode, and then an execute path chosen by the instruction class. The classes are operand read and accumulator update, store, and branch.

The datapath has these registers:
- a program counter;
- an instruction register, split into a 4-bit operation and a 12-bit address;
- an address register, loaded either from the program counter (for a fetch) or from the address field (for an operand access);
- a read buffer;
- the accumulator;
- negative and zero flags.

The control unit drives a separate load enable for each register. Arithmetic and logic instructions combine the accumulator with a memory word and write the result back to the accumulator. Conditional branches test the flags that the last accumulator update left behind.

To use the core, the integrator places a program at address 0, releases reset, and waits for the halted output. The accumulator value is brought out for observation.

Top module: `acc_cpu`

## Requirements
- R1: While reset is low, and in the cycle after it is released, mem_rd, mem_wr and halted are 0 and acc_value is 0. The first memory read after reset uses address 0.
- R2: An instruction word holds the operation in bits 15:12 and the address in bits 11:0. The operation codes are: LOAD=0, STORE=1, ADD=2, SUB=3, AND=4, BRZ=5, BRN=6, JMP=7, HALT=15.
- R3: LOAD sets the accumulator to Mem[addr].
- R4: ADD sets the accumulator to (AC + Mem[addr]) mod 2^16. SUB sets it to (AC - Mem[addr]) mod 2^16.
- R5: AND sets the accumulator to AC bitwise-AND Mem[addr].
- R6: STORE writes the accumulator to Mem[addr]. It asserts mem_wr for exactly one cycle and leaves the accumulator unchanged.
- R7: BRZ moves to addr when the last accumulator update gave zero. Otherwise execution continues with the next word.
- R8: BRN moves to addr when bit 15 of the last accumulator update was 1. Otherwise execution continues with the next word.
- R9: JMP always continues execution at addr.
- R10: Operation codes 8 to 14 change nothing except the program counter, which advances by one.
- R11: After HALT, halted stays 1 and mem_rd and mem_wr stay 0 until reset. No later instruction takes effect.
- R12: Read data is taken in the cycle after mem_rd is asserted. mem_rd and mem_wr are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 12 | Word address for a read or write |
| mem_rd | output | 1 | Read strobe; the data is expected on mem_rdata in the next cycle |
| mem_wr | output | 1 | Write strobe for mem_wdata at mem_addr |
| mem_wdata | output | 16 | Write data, which is the accumulator |
| mem_rdata | input | 16 | Read data from memory |
| acc_value | output | 16 | Current accumulator contents |
| halted | output | 1 | High once HALT has executed |

## Verification
Most internal errors show at the ports within one instruction, which is at most seven cycles. A wrong state sequence shows as a strobe at the wrong time or an address from the wrong source. A bad ALU result or bad flags shows up in the next STORE, or as a branch that goes the wrong way and writes a different marker word. Guard words sit after the HALT and after the skipped branch paths, so a counter or decode fault that runs past them leaves a changed word in memory. The programs are swept over operand pairs chosen at the sign and carry boundaries.

// File: rtl/acc_pkg.sv
// Package: operation codes, control states and widths shared by the core.
// Assumes a 4-bit operation field at the top of each instruction word.
package acc_pkg;
    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_LOAD  = 4'h0;
    localparam logic [OP_W-1:0] OP_STORE = 4'h1;
    localparam logic [OP_W-1:0] OP_ADD   = 4'h2;
    localparam logic [OP_W-1:0] OP_SUB   = 4'h3;
    localparam logic [OP_W-1:0] OP_AND   = 4'h4;
    localparam logic [OP_W-1:0] OP_BRZ   = 4'h5;
    localparam logic [OP_W-1:0] OP_BRN   = 4'h6;
    localparam logic [OP_W-1:0] OP_JMP   = 4'h7;
    localparam logic [OP_W-1:0] OP_HALT  = 4'hF;

    typedef enum logic [3:0] {
        ST_INIT,
        ST_FETCH,
        ST_FREAD,
        ST_FWAIT,
        ST_DECODE,
        ST_OPRD,
        ST_OPWAIT,
        ST_EXEC,
        ST_STORE,
        ST_JUMP,
        ST_HALT
    } ctrl_state_t;

    // Register load enables issued by the control unit.
    typedef struct packed {
        logic mar_ld;
        logic mar_from_pc;
        logic ir_ld;
        logic pc_inc;
        logic pc_ld;
        logic mbr_ld;
        logic ac_ld;
    } dp_ctrl_t;
endpackage

// File: rtl/acc_alu.sv
// Accumulator ALU: combines the accumulator with a memory operand.
// Assumes the operation code comes straight from the instruction register;
// for any code other than ADD, SUB or AND the operand passes through (LOAD).
module acc_alu
    import acc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result
);
    // Select the result for the current operation.
    always_comb begin
        case (op)
            OP_ADD:  result = acc + operand;
            OP_SUB:  result = acc - operand;
            OP_AND:  result = acc & operand;
            default: result = operand;
        endcase
    end
endmodule

// File: rtl/acc_ctrl.sv
// Control unit: Moore state machine that sequences fetch, decode and the
// class-specific execute paths. Every output depends only on the state;
// the opcode and flags only steer the next-state choice in DECODE.
// Assumes memory returns read data one cycle after mem_rd.
module acc_ctrl
    import acc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    input  logic            flag_z,
    input  logic            flag_n,
    output dp_ctrl_t        dp,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            halted
);
    ctrl_state_t state, state_nx;

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_INIT;
        else        state <= state_nx;
    end

    // Next-state choice; DECODE branches by instruction class.
    always_comb begin
        state_nx = state;
        case (state)
            ST_INIT:   state_nx = ST_FETCH;
            ST_FETCH:  state_nx = ST_FREAD;
            ST_FREAD:  state_nx = ST_FWAIT;
            ST_FWAIT:  state_nx = ST_DECODE;
            ST_DECODE: begin
                case (opcode)
                    OP_LOAD, OP_ADD, OP_SUB, OP_AND: state_nx = ST_OPRD;
                    OP_STORE: state_nx = ST_STORE;
                    OP_BRZ:   state_nx = flag_z ? ST_JUMP : ST_FETCH;
                    OP_BRN:   state_nx = flag_n ? ST_JUMP : ST_FETCH;
                    OP_JMP:   state_nx = ST_JUMP;
                    OP_HALT:  state_nx = ST_HALT;
                    default:  state_nx = ST_FETCH;
                endcase
            end
            ST_OPRD:   state_nx = ST_OPWAIT;
            ST_OPWAIT: state_nx = ST_EXEC;
            ST_EXEC:   state_nx = ST_FETCH;
            ST_STORE:  state_nx = ST_FETCH;
            ST_JUMP:   state_nx = ST_FETCH;
            ST_HALT:   state_nx = ST_HALT;
            default:   state_nx = ST_INIT;
        endcase
    end

    // Moore outputs decoded from the state alone.
    always_comb begin
        dp             = '0;
        dp.mar_ld      = (state == ST_FETCH) || (state == ST_DECODE);
        dp.mar_from_pc = (state == ST_FETCH);
        dp.ir_ld       = (state == ST_FWAIT);
        dp.pc_inc      = (state == ST_FWAIT);
        dp.pc_ld       = (state == ST_JUMP);
        dp.mbr_ld      = (state == ST_OPWAIT);
        dp.ac_ld       = (state == ST_EXEC);
        mem_rd         = (state == ST_FREAD) || (state == ST_OPRD);
        mem_wr         = (state == ST_STORE);
        halted         = (state == ST_HALT);
    end

    // R12
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R12
    fetch_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp.ir_ld |-> $past(mem_rd));
endmodule

// File: rtl/acc_datapath.sv
// Datapath: program counter, instruction register, address register,
// read buffer, accumulator and N/Z flags, each with its own load enable.
// Assumes at most one of pc_inc and pc_ld is active in a cycle.
module acc_datapath
    import acc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dp_ctrl_t          dp,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] acc,
    output logic [OP_W-1:0]   opcode,
    output logic              flag_z,
    output logic              flag_n
);
    localparam int OP_LSB = DATA_W - OP_W;

    logic [ADDR_W-1:0] pc;
    logic [DATA_W-1:0] ir;
    logic [ADDR_W-1:0] mar;
    logic [DATA_W-1:0] mbr;
    logic [DATA_W-1:0] alu_y;
    logic [ADDR_W-1:0] ir_addr;

    assign opcode   = ir[DATA_W-1:OP_LSB];
    assign ir_addr  = ir[ADDR_W-1:0];
    assign mem_addr = mar;

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .op      (opcode),
        .acc     (acc),
        .operand (mbr),
        .result  (alu_y)
    );

    // Program counter: cleared on reset, steps after fetch, loads on branch.
    always_ff @(posedge clk) begin
        if (!rst_n)         pc <= '0;
        else if (dp.pc_ld)  pc <= ir_addr;
        else if (dp.pc_inc) pc <= pc + 1'b1;
    end

    // Instruction register and address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir  <= '0;
            mar <= '0;
        end else begin
            if (dp.ir_ld)  ir  <= mem_rdata;
            if (dp.mar_ld) mar <= dp.mar_from_pc ? pc : ir_addr;
        end
    end

    // Read buffer captures the operand word.
    always_ff @(posedge clk) begin
        if (!rst_n)         mbr <= '0;
        else if (dp.mbr_ld) mbr <= mem_rdata;
    end

    // Accumulator and flags update together from the ALU.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            flag_z <= 1'b0;
            flag_n <= 1'b0;
        end else if (dp.ac_ld) begin
            acc    <= alu_y;
            flag_z <= (alu_y == '0);
            flag_n <= alu_y[DATA_W-1];
        end
    end

    // R6
    ac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dp.ac_ld |=> $stable(acc));

    // R7
    flag_z_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp.ac_ld |=> (flag_z == (acc == '0)));

    // R8
    flag_n_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp.ac_ld |=> (flag_n == acc[DATA_W-1]));
endmodule

// File: rtl/acc_cpu.sv
// Top: accumulator processor core on one shared synchronous memory port.
// Assumes a program starts at word 0 and memory answers reads one cycle late.
module acc_cpu
    import acc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] acc_value,
    output logic              halted
);
    dp_ctrl_t        dp;
    logic [OP_W-1:0] opcode;
    logic            flag_z;
    logic            flag_n;
    logic [DATA_W-1:0] acc;

    acc_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (opcode),
        .flag_z (flag_z),
        .flag_n (flag_n),
        .dp     (dp),
        .mem_rd (mem_rd),
        .mem_wr (mem_wr),
        .halted (halted)
    );

    acc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .dp        (dp),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .acc       (acc),
        .opcode    (opcode),
        .flag_z    (flag_z),
        .flag_n    (flag_n)
    );

    assign mem_wdata = acc;
    assign acc_value = acc;

    // R11
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_rd && !mem_wr));
endmodule

// File: tb/acc_cpu_test.sv
// Bench: runs small programs over swept operands and checks memory and AC.
module acc_cpu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr, halted;
    logic [15:0] mem_wdata, acc_value;
    logic [15:0] mem_rdata = '0;
    logic [15:0] mem [0:255];

    int checks = 0;
    int errors = 0;
    logic [15:0] vals [0:6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                                16'hFFFF, 16'h1234, 16'h00F0};

    always #10 clk = ~clk;

    acc_cpu uut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .acc_value(acc_value), .halted(halted)
    );

    // Behavioural synchronous memory; read data appears one cycle later.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_wr) mem[mem_addr[7:0]] = mem_wdata;
    end

    initial begin
        #4000000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
        return {op, a};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    // Reset, run to halt, then watch the strobes stay quiet.
    task automatic run_prog();
        int cyc;
        logic both;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 rd/wr/halt", {13'b0, mem_rd, mem_wr, halted}, 16'h0);
        chk("R1 acc", acc_value, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 post-release", {13'b0, mem_rd, mem_wr, halted}, 16'h0);
        while (!mem_rd) @(negedge clk);
        chk("R1 first read addr", {4'b0, mem_addr}, 16'h0);
        cyc = 0; both = 1'b0;
        while (!halted && cyc < 2000) begin
            if (mem_rd && mem_wr) both = 1'b1;
            @(negedge clk); cyc++;
        end
        chk("R11 halted reached", {15'b0, halted}, 16'h1);
        chk("R12 rd/wr exclusive", {15'b0, both}, 16'h0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (mem_rd || mem_wr || !halted) both = 1'b1;
        end
        chk("R11 quiet after halt", {15'b0, both}, 16'h0);
    endtask

    initial begin
        // Arithmetic sweep: R2 encoding, R3 LOAD, R4 ADD/SUB, R5 AND, R6 STORE.
        for (int i = 0; i < 7; i++) begin
            for (int j = 0; j < 7; j++) begin
                logic [15:0] a, b;
                a = vals[i]; b = vals[j];
                clear_mem();
                mem[0]  = ins(4'h0, 12'h040);
                mem[1]  = ins(4'h2, 12'h041);
                mem[2]  = ins(4'h1, 12'h050);
                mem[3]  = ins(4'h0, 12'h040);
                mem[4]  = ins(4'h3, 12'h041);
                mem[5]  = ins(4'h1, 12'h051);
                mem[6]  = ins(4'h0, 12'h040);
                mem[7]  = ins(4'h4, 12'h041);
                mem[8]  = ins(4'h1, 12'h052);
                mem[9]  = ins(4'h0, 12'h041);
                mem[10] = ins(4'hF, 12'h000);
                mem[11] = ins(4'h1, 12'h053);
                mem[8'h40] = a; mem[8'h41] = b; mem[8'h53] = 16'hBEEF;
                run_prog();
                chk("R4 ADD", mem[8'h50], a + b);
                chk("R4 SUB", mem[8'h51], a - b);
                chk("R5 AND", mem[8'h52], a & b);
                chk("R3 LOAD acc", acc_value, b);
                chk("R11 no store after HALT", mem[8'h53], 16'hBEEF);
                chk("R6 operand untouched", mem[8'h40], a);
            end
        end
        // Branch sweep: R7 BRZ, R8 BRN, R9 JMP, R10 undefined code.
        for (int i = 0; i < 7; i++) begin
            logic [15:0] x;
            x = vals[i];
            clear_mem();
            mem[0]  = ins(4'h0, 12'h080);
            mem[1]  = ins(4'h5, 12'h005);
            mem[2]  = ins(4'h0, 12'h081);
            mem[3]  = ins(4'h1, 12'h090);
            mem[4]  = ins(4'h7, 12'h007);
            mem[5]  = ins(4'h0, 12'h082);
            mem[6]  = ins(4'h1, 12'h090);
            mem[7]  = ins(4'h0, 12'h080);
            mem[8]  = ins(4'h6, 12'h00B);
            mem[9]  = ins(4'h0, 12'h081);
            mem[10] = ins(4'h7, 12'h00C);
            mem[11] = ins(4'h0, 12'h082);
            mem[12] = ins(4'h1, 12'h091);
            mem[13] = ins(4'hA, 12'h092);
            mem[14] = ins(4'hF, 12'h000);
            mem[15] = ins(4'h1, 12'h093);
            mem[8'h80] = x; mem[8'h81] = 16'd1; mem[8'h82] = 16'd2;
            mem[8'h92] = 16'h5A5A; mem[8'h93] = 16'hDEAD;
            run_prog();
            chk("R7 BRZ path", mem[8'h90], (x == 16'h0) ? 16'd2 : 16'd1);
            chk("R8 BRN path", mem[8'h91], x[15] ? 16'd2 : 16'd1);
            chk("R9 JMP final acc", acc_value, x[15] ? 16'd2 : 16'd1);
            chk("R10 undefined code no-op", mem[8'h92], 16'h5A5A);
            chk("R11 no store after HALT", mem[8'h93], 16'hDEAD);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule